// File: doc/BRIEF.md
# Pipelined Burst Synchronous Static RAM

This block is a synthesizable, cycle-accurate model of a synchronous static RAM that serves four-word bursts. Every access control and the write data are registered on the rising clock edge. A burst opens on one of two start strobes. One belongs to the processor side and always reads. The other belongs to the memory controller and reads or writes according to the write qualifiers. Each later word of the burst comes from a 2-bit counter that steps only on cycles where the advance strobe is low. A static order pin chooses how the counter maps onto the two low address bits.

Read data passes through an output register, so a word read on one edge is presented after the next edge. The output drivers are modelled by a drive flag, not by a tri-state bus. A deselect therefore removes the drive one edge after the last read word has been presented. Writes can be narrowed to 9-bit byte lanes or widened to the full word with a global write. A sleep input freezes access and turns the drivers off at once. An output enable gates only the drivers. The reset clears the pipeline and the burst state but leaves the array alone.

Top module: `burst_sram`

## Requirements
- R1: Controls are sampled on the rising edge. A read sampled on edge t shows its word on `dataOut` with `dataDrive` high after edge t+1, and the word stays there until the next read is presented.
- R2: `startCtlN` low with `selN` low loads `addr` as the burst start. The access is a write when a write qualifier is active and a read otherwise.
- R3: When no strobe is taken during an open burst, `advanceN` low steps the 2-bit counter before the access. `advanceN` high accesses the same address again.
- R4: With `orderIlv` = 0 the two low address bits are the start value plus the count, modulo 4. With `orderIlv` = 1 they are the start value XOR the count.
- R5: A burst wraps inside its aligned 4-word block. Address bits above bit 1 never change during a burst.
- R6: With `wrEnN` low and `allWrN` high, only the lanes whose `laneWrN` bit is low are written. Lane i is bits [9i+8:9i]. The other lanes keep their contents.
- R7: `allWrN` low writes every lane, whatever the state of `wrEnN` and `laneWrN`.
- R8: `startCpuN` low with `selN` low starts a read at `addr` even if write qualifiers are active. It takes precedence over `startCtlN` on the same edge.
- R9: `startCpuN` is ignored while `selN` is high, and an open burst carries on. `startCtlN` low with `selN` high deselects: the word already presented stays driven for one more edge, and then `dataDrive` falls.
- R10: While `sleep` is high, no access starts or continues and the array keeps its contents. `dataDrive` is forced low at once, and the open burst is closed.
- R11: `outEnN` high forces `dataDrive` low without an edge and without touching the pipeline. Driving `outEnN` low again shows the held word.
- R12: While `rstN` is low, `dataDrive` goes low and no burst is open. After reset, a continuation cycle performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset of the pipeline and burst state, active low |
| addr | input | ADDR_W | Burst start address |
| startCpuN | input | 1 | Processor-side burst start, read only, active low |
| startCtlN | input | 1 | Controller-side burst start or deselect, active low |
| advanceN | input | 1 | Burst counter step, active low |
| orderIlv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| laneWrN | input | LANES | Per-lane write enables, active low |
| allWrN | input | 1 | Global write of all lanes, active low |
| wrEnN | input | 1 | Write enable that qualifies `laneWrN`, active low |
| selN | input | 1 | Chip select, active low |
| outEnN | input | 1 | Asynchronous output drive gate, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dataIn | input | DATA_W | Write data, sampled with the write command |
| dataOut | output | DATA_W | Output register contents |
| dataDrive | output | 1 | High when the output drivers are on |

## Verification
The assertions assume that `orderIlv` stays fixed while a burst is open. They also assume that `sleep` and `outEnN` are changed only away from the clock edge, and that an address is read only after it has been written. The directed stimulus keeps to these limits. It changes every input one nanosecond after a rising edge, and it switches `orderIlv` only after a burst has been closed with a deselect. Each address it reads is filled first, either by a full-word burst or by a global write.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;

  // Access strobes that the control stage hands to the datapath
  typedef struct packed {
    logic rd;
    logic wr;
  } accessStrobe_t;

  // Low two address bits of a burst word, given the start value and the step count
  function automatic logic [1:0] burstLow(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              startCpuN,
  input  logic              startCtlN,
  input  logic              advanceN,
  input  logic              orderIlv,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              allWrN,
  input  logic              wrEnN,
  input  logic              selN,
  input  logic              sleep,
  output accessStrobe_t     stb,
  output logic [ADDR_W-1:0] accAddr,
  output logic [LANES-1:0]  accMask
);

  logic              active;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        cnt, nextCnt;
  logic              cpuGo, ctlGo, ctlDesel, contGo, wrQual;
  logic [LANES-1:0]  wrMask;
  logic [ADDR_W-1:0] contAddr;

  always_comb begin
    cpuGo    = !sleep && !startCpuN && !selN;
    ctlGo    = !sleep && !cpuGo && !startCtlN && !selN;
    ctlDesel = !sleep && !startCtlN && selN;
    contGo   = !sleep && !cpuGo && startCtlN && active;
    if (!allWrN)     wrMask = '1;
    else if (!wrEnN) wrMask = ~laneWrN;
    else             wrMask = '0;
    wrQual   = |wrMask;
    nextCnt  = (contGo && !advanceN) ? cnt + 2'd1 : cnt;
    contAddr = {baseAddr[ADDR_W-1:2], burstLow(baseAddr[1:0], nextCnt, orderIlv)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      baseAddr <= '0;
      cnt      <= '0;
      stb      <= '0;
      accAddr  <= '0;
      accMask  <= '0;
    end else begin
      stb.rd  <= cpuGo || ((ctlGo || contGo) && !wrQual);
      stb.wr  <= (ctlGo || contGo) && wrQual;
      accMask <= cpuGo ? '0 : wrMask;
      accAddr <= (cpuGo || ctlGo) ? addr : contAddr;
      if (cpuGo || ctlGo) begin
        active   <= 1'b1;
        baseAddr <= addr;
        cnt      <= '0;
      end else begin
        if (ctlDesel || sleep) active <= 1'b0;
        cnt <= nextCnt;
      end
    end
  end

  AST_CPU_READS: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !startCpuN && !selN) |=> (stb.rd && !stb.wr && accAddr == $past(addr))) // R8
    else $error("processor start did not become a read");

  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> (!stb.rd && !stb.wr)) // R10
    else $error("access issued during sleep");

  AST_WRAP_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (active && startCpuN && startCtlN && !advanceN && !sleep)
      |=> (accAddr[ADDR_W-1:2] == $past(accAddr[ADDR_W-1:2]))) // R5
    else $error("burst left its 4-word block");

  AST_IGNORED_START: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !startCpuN && selN && startCtlN) |=> (!stb.rd && !stb.wr)) // R9
    else $error("processor start accepted while deselected");

endmodule

// File: rtl/burst_sram_dp.sv
`timescale 1ns/1ps
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18,
  parameter int LANES  = 2,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  accessStrobe_t     stb,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [LANES-1:0]  accMask,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEnN,
  input  logic              sleep,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);

  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wrData, outReg, bitMask;
  logic              drvReg;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bitMask[l*LANE_W +: LANE_W] = {LANE_W{accMask[l]}};
  end

  // write data travels with the command sampled on the same edge
  always_ff @(posedge clk) begin
    wrData <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (stb.wr) mem[accAddr] <= (mem[accAddr] & ~bitMask) | (wrData & bitMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      drvReg <= 1'b0;
      outReg <= '0;
    end else begin
      drvReg <= stb.rd;
      if (stb.rd) outReg <= mem[accAddr];
    end
  end

  assign dataOut   = outReg;
  assign dataDrive = drvReg && !outEnN && !sleep;

  AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && !accMask[0])
      |=> (mem[$past(accAddr)][LANE_W-1:0] == $past(mem[accAddr][LANE_W-1:0]))) // R6
    else $error("unmasked lane 0 was changed");

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && !stb.rd) |=> !dataDrive) // R2
    else $error("output driven after a write cycle");

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              startCpuN,
  input  logic              startCtlN,
  input  logic              advanceN,
  input  logic              orderIlv,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              allWrN,
  input  logic              wrEnN,
  input  logic              selN,
  input  logic              outEnN,
  input  logic              sleep,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);

  localparam int DEPTH = 1 << ADDR_W;

  accessStrobe_t     stb;
  logic [ADDR_W-1:0] accAddr;
  logic [LANES-1:0]  accMask;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .startCpuN(startCpuN),
    .startCtlN(startCtlN), .advanceN(advanceN), .orderIlv(orderIlv),
    .laneWrN(laneWrN), .allWrN(allWrN), .wrEnN(wrEnN), .selN(selN),
    .sleep(sleep), .stb(stb), .accAddr(accAddr), .accMask(accMask)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .accAddr(accAddr), .accMask(accMask),
    .dataIn(dataIn), .outEnN(outEnN), .sleep(sleep),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

endmodule

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

  localparam int AW = 8;
  localparam int DW = 18;
  localparam int NL = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr;
  logic startCpuN, startCtlN, advanceN, orderIlv, allWrN, wrEnN, selN, outEnN, sleep;
  logic [NL-1:0] laneWrN;
  logic [DW-1:0] dataIn, dataOut;
  logic dataDrive;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] words [4];

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .startCpuN(startCpuN),
    .startCtlN(startCtlN), .advanceN(advanceN), .orderIlv(orderIlv),
    .laneWrN(laneWrN), .allWrN(allWrN), .wrEnN(wrEnN), .selN(selN),
    .outEnN(outEnN), .sleep(sleep), .dataIn(dataIn),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  task automatic setIdle();
    startCpuN = 1'b1; startCtlN = 1'b1; advanceN = 1'b1;
    laneWrN = '1; allWrN = 1'b1; wrEnN = 1'b1; selN = 1'b0;
    outEnN = 1'b0; sleep = 1'b0; addr = '0; dataIn = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkOut(string req, logic expDrv, logic [DW-1:0] expData);
    checks++;
    if (dataDrive !== expDrv || (expDrv && dataOut !== expData)) begin
      errors++;
      $display("FAIL %s: drive=%0b data=%05h expected drive=%0b data=%05h",
               req, dataDrive, dataOut, expDrv, expData);
    end
  endtask

  task automatic deselect();
    setIdle(); startCtlN = 1'b0; selN = 1'b1; tick();
    setIdle(); tick();
  endtask

  task automatic readStart(logic [AW-1:0] a);
    setIdle(); startCpuN = 1'b0; addr = a; tick();
  endtask

  // global write of four words (R7) via controller start, linear order
  task automatic fillBurst(logic [AW-1:0] base);
    setIdle(); startCtlN = 1'b0; addr = base; allWrN = 1'b0; dataIn = words[0]; tick();
    for (int i = 1; i < 4; i++) begin
      setIdle(); advanceN = 1'b0; allWrN = 1'b0; dataIn = words[i]; tick();
    end
    deselect();
  endtask

  task automatic testReset();
    setIdle(); orderIlv = 1'b0;
    repeat (3) tick();
    checkOut("R12 drive low in reset", 1'b0, '0);
    rstN = 1'b1;
    tick(); tick();
    checkOut("R12 no burst after reset", 1'b0, '0);
  endtask

  task automatic testLinear();
    fillBurst(8'h10);
    readStart(8'h12);
    checkOut("R7 global write seen", 1'b0, '0);
    setIdle(); advanceN = 1'b0; tick();
    checkOut("R1 first word latency", 1'b1, words[2]);
    tick();
    checkOut("R4 linear step", 1'b1, words[3]);
    tick();
    checkOut("R5 wrap to block start", 1'b1, words[0]);
    setIdle(); tick();
    checkOut("R4 linear last word", 1'b1, words[1]);
    tick();
    checkOut("R3 hold address without advance", 1'b1, words[1]);
    deselect();
  endtask

  task automatic testInterleave();
    orderIlv = 1'b1;
    readStart(8'h11);
    setIdle(); advanceN = 1'b0; tick();
    checkOut("R4 ilv word0", 1'b1, words[1]);
    tick();
    checkOut("R4 ilv word1", 1'b1, words[0]);
    tick();
    checkOut("R4 ilv word2", 1'b1, words[3]);
    setIdle(); tick();
    checkOut("R4 ilv word3", 1'b1, words[2]);
    deselect();
    orderIlv = 1'b0;
  endtask

  task automatic testLanes();
    logic [DW-1:0] exp0, exp1;
    setIdle(); startCtlN = 1'b0; addr = 8'h20; allWrN = 1'b0; dataIn = 18'h3FFFF; tick();
    setIdle(); startCtlN = 1'b0; addr = 8'h20; wrEnN = 1'b0; laneWrN = 2'b10; dataIn = 18'h00000; tick();
    exp0 = 18'h3FE00;
    readStart(8'h20);
    setIdle(); startCtlN = 1'b0; selN = 1'b1; tick();
    checkOut("R6 lane0 only", 1'b1, exp0);
    setIdle(); startCtlN = 1'b0; addr = 8'h20; wrEnN = 1'b0; laneWrN = 2'b01; dataIn = 18'h15555; tick();
    exp1 = (18'h15555 & 18'h3FE00) | (exp0 & 18'h001FF);
    readStart(8'h20);
    setIdle(); startCtlN = 1'b0; selN = 1'b1; tick();
    checkOut("R6 lane1 only", 1'b1, exp1);
    setIdle(); tick();
  endtask

  task automatic testPriority();
    setIdle(); startCpuN = 1'b0; startCtlN = 1'b0; addr = 8'h12;
    allWrN = 1'b0; wrEnN = 1'b0; laneWrN = '0; dataIn = 18'h0BEEF; tick();
    setIdle(); startCtlN = 1'b0; selN = 1'b1; tick();
    checkOut("R8 both strobes read", 1'b1, words[2]);
    setIdle(); tick();
    readStart(8'h12);
    setIdle(); startCtlN = 1'b0; selN = 1'b1; tick();
    checkOut("R8 no write happened", 1'b1, words[2]);
    setIdle(); tick();
  endtask

  task automatic testIgnoredStart();
    readStart(8'h10);
    setIdle(); startCpuN = 1'b0; selN = 1'b1; addr = 8'h30; advanceN = 1'b0; tick();
    checkOut("R9 burst start word", 1'b1, words[0]);
    setIdle(); startCtlN = 1'b0; selN = 1'b1; tick();
    checkOut("R9 deselected start ignored", 1'b1, words[1]);
    setIdle(); tick();
  endtask

  task automatic testDeselect();
    readStart(8'h13);
    setIdle(); startCtlN = 1'b0; selN = 1'b1; tick();
    checkOut("R9 word still driven after deselect", 1'b1, words[3]);
    setIdle(); tick();
    checkOut("R9 drive off two edges after", 1'b0, '0);
    tick();
    checkOut("R9 burst closed", 1'b0, '0);
  endtask

  task automatic testSleep();
    setIdle(); sleep = 1'b1; startCtlN = 1'b0; addr = 8'h10; allWrN = 1'b0; dataIn = 18'h2AAAA; tick();
    setIdle(); tick();
    readStart(8'h10);
    setIdle(); startCtlN = 1'b0; selN = 1'b1; tick();
    checkOut("R10 contents kept", 1'b1, words[0]);
    sleep = 1'b1; #1;
    checkOut("R10 drive off at once", 1'b0, '0);
    sleep = 1'b0; #1;
    setIdle(); tick();
    checkOut("R10 idle after sleep", 1'b0, '0);
  endtask

  task automatic testOutEnable();
    readStart(8'h11);
    setIdle(); startCtlN = 1'b0; selN = 1'b1; outEnN = 1'b1; tick();
    checkOut("R11 gated off", 1'b0, '0);
    outEnN = 1'b0; #1;
    checkOut("R11 held word returns", 1'b1, words[1]);
    setIdle(); tick();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    words[0] = 18'h0A5A5; words[1] = 18'h1C3C3;
    words[2] = 18'h2F00F; words[3] = 18'h3123A;
    setIdle(); orderIlv = 1'b0;
    testReset();
    testLinear();
    testInterleave();
    testLanes();
    testPriority();
    testIgnoredStart();
    testDeselect();
    testSleep();
    testOutEnable();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule